// File: doc/BRIEF.md
# Delayed Transaction Match Tracker

This block sits in a bus target or bridge that cannot answer a request on the spot. The first time a master asks, the tracker stores the attributes of the request and answers with retry. It then sends the stored request toward the far side and waits for the completion. Every later attempt by a master is compared against the stored entry. A hit collects the completion and frees the entry. A miss gets retry and leaves the entry exactly as it was.

The comparison can run under a strict policy or a relaxed one. The relaxed policy lets one read command stand in for another read command, and lets a request change between 64-bit and 32-bit width. A separate setting drops the byte enables from the comparison for reads to prefetchable space. If nobody collects a finished completion, a discard timer frees the entry. A saturating counter records how many times that has happened.

Top module: `dly_txn_tracker`

## Requirements
- R1: After reset, `st_state` is 0 (idle), `st_discards` is 0, and `rsp_valid`, `rsp_retry`, `rsp_done` and `fwd_valid` are all low.
- R2: A request in idle is captured and answered with retry one cycle later. In that same cycle `fwd_valid` pulses with the captured attributes on the `fwd_*` ports, and `st_state` becomes 1 (pending).
- R3: Any request while pending gets retry. A `cpl_valid` pulse while pending stores `cpl_data` and moves `st_state` to 2 (complete).
- R4: In complete, a request hits only when all of the following match the stored entry: address, command, byte enables, write data (for writes), parity (when `cfg_par_en` is set), the 64-bit flag (when `cfg_64_en` is set) and the lock flag (when `cfg_lock_en` is set). A hit returns `rsp_done` with the stored completion on `rsp_data` one cycle later, and the entry goes back to idle.
- R5: A request that misses while the entry is occupied gets retry. It changes neither the stored attributes nor the discard timer.
- R6: With `cfg_be_skip` set, byte enables are left out of the comparison for read entries that were captured with `req_pref` high. Entries that are not prefetchable still compare byte enables.
- R7: Command bit 0 set means write. With `cfg_relaxed` set, any read command matches any other read command. Write commands always need an exact match.
- R8: With `cfg_relaxed` set, a difference in the 64-bit flag does not prevent a hit. With `cfg_relaxed` clear and `cfg_64_en` set, it does.
- R9: A completion left unclaimed for 2^DISCARD_W cycles after entering complete is discarded: the entry returns to idle and `st_discards` increments.
- R10: `st_discards` saturates at its all-ones value.
- R11: A `cpl_valid` pulse outside pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_relaxed | input | 1 | Selects the relaxed matching policy |
| cfg_be_skip | input | 1 | Leaves byte enables out of the comparison for prefetchable reads |
| cfg_par_en | input | 1 | Captures and compares parity |
| cfg_64_en | input | 1 | Captures and compares the 64-bit flag |
| cfg_lock_en | input | 1 | Captures and compares the lock flag |
| req_valid | input | 1 | A master request attempt, one cycle |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | CMD_W | Bus command; bit 0 set means write |
| req_be | input | BE_W | Byte enables |
| req_par | input | PAR_W | Parity bits |
| req_wdata | input | DATA_W | Write data |
| req_is64 | input | 1 | 64-bit request flag |
| req_lock | input | 1 | Lock flag |
| req_pref | input | 1 | Request targets prefetchable space |
| rsp_valid | output | 1 | A response to the previous cycle's request |
| rsp_retry | output | 1 | The response is retry |
| rsp_done | output | 1 | The response is a hit that carries the completion |
| rsp_data | output | DATA_W | Completion data on a hit |
| fwd_valid | output | 1 | Launches the stored request to the far side |
| fwd_addr | output | ADDR_W | Stored address |
| fwd_cmd | output | CMD_W | Stored command |
| fwd_be | output | BE_W | Stored byte enables |
| fwd_wdata | output | DATA_W | Stored write data |
| fwd_is64 | output | 1 | Stored 64-bit flag |
| fwd_lock | output | 1 | Stored lock flag |
| cpl_valid | input | 1 | Far-side completion, one cycle |
| cpl_data | input | DATA_W | Far-side completion data |
| st_state | output | 2 | Entry state: 0 idle, 1 pending, 2 complete |
| st_discards | output | DCNT_W | Saturating count of discard-timer expirations |

## Verification
Some properties are checked by assertions on every cycle. These are: retry for every attempt while pending, the launch pulse after a capture, that retry and done never appear together, that a hit leaves the entry idle, that stored attributes stay unchanged between captures, the counter step on each expiry and its saturation, and that a write hit always carried the exact command. Other behaviour can only be shown by the bench's scenarios. This covers whether a given pair of requests hits or misses under each policy setting (read aliasing, byte-enable masking, 64/32 tolerance, parity and write data). It also covers the exact expiry cycle with and without a miss during the wait, and the return of the correct completion data.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

  typedef enum logic [1:0] {
    DT_IDLE = 2'd0,
    DT_PEND = 2'd1,
    DT_DONE = 2'd2
  } dt_state_e;

  // bit 0 of a bus command marks a write
  function automatic logic cmd_is_write(input logic cmd_lsb);
    return cmd_lsb;
  endfunction

  // exact command, or two reads under the relaxed policy
  function automatic logic cmd_compatible(input logic same, input logic req_wr,
                                          input logic st_wr, input logic relaxed);
    return same || (relaxed && !req_wr && !st_wr);
  endfunction

  // an attribute matches if equal, not compared, or tolerated
  function automatic logic attr_compatible(input logic same, input logic compared,
                                           input logic tolerate);
    return same || !compared || tolerate;
  endfunction

endpackage

// File: rtl/dtt_store.sv
module dtt_store #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int CMD_W  = 4,
  parameter int PAR_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              cfg_par_en,
  input  logic              cfg_64_en,
  input  logic              cfg_lock_en,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CMD_W-1:0]  in_cmd,
  input  logic [BE_W-1:0]   in_be,
  input  logic [PAR_W-1:0]  in_par,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              in_is64,
  input  logic              in_lock,
  input  logic              in_pref,
  input  logic              cpl_load,
  input  logic [DATA_W-1:0] cpl_data,
  output logic [ADDR_W-1:0] st_addr,
  output logic [CMD_W-1:0]  st_cmd,
  output logic [BE_W-1:0]   st_be,
  output logic [PAR_W-1:0]  st_par,
  output logic [DATA_W-1:0] st_wdata,
  output logic              st_is64,
  output logic              st_lock,
  output logic              st_pref,
  output logic [DATA_W-1:0] st_cdata
);

  logic in_wr;
  assign in_wr = dtt_pkg::cmd_is_write(in_cmd[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_addr  <= '0;
      st_cmd   <= '0;
      st_be    <= '0;
      st_par   <= '0;
      st_wdata <= '0;
      st_is64  <= 1'b0;
      st_lock  <= 1'b0;
      st_pref  <= 1'b0;
    end else if (cap_en) begin
      st_addr  <= in_addr;
      st_cmd   <= in_cmd;
      st_be    <= in_be;
      st_par   <= cfg_par_en ? in_par : '0;
      st_wdata <= in_wr ? in_wdata : '0;
      st_is64  <= cfg_64_en & in_is64;
      st_lock  <= cfg_lock_en & in_lock;
      st_pref  <= in_pref;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st_cdata <= '0;
    else if (cpl_load) st_cdata <= cpl_data;
  end

  AST_HOLD_ON_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(st_addr) && $stable(st_cmd) && $stable(st_be) && $stable(st_wdata))); // R5

  AST_CDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cpl_load |=> $stable(st_cdata)); // R11

endmodule

// File: rtl/dtt_match.sv
module dtt_match #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int CMD_W  = 4,
  parameter int PAR_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_relaxed,
  input  logic              cfg_be_skip,
  input  logic              cfg_par_en,
  input  logic              cfg_64_en,
  input  logic              cfg_lock_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [BE_W-1:0]   req_be,
  input  logic [PAR_W-1:0]  req_par,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_is64,
  input  logic              req_lock,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [CMD_W-1:0]  st_cmd,
  input  logic [BE_W-1:0]   st_be,
  input  logic [PAR_W-1:0]  st_par,
  input  logic [DATA_W-1:0] st_wdata,
  input  logic              st_is64,
  input  logic              st_lock,
  input  logic              st_pref,
  output logic              hit
);

  import dtt_pkg::*;

  logic req_wr, st_wr;
  logic addr_ok, cmd_ok, be_ok, par_ok, data_ok, w64_ok, lock_ok;
  logic be_masked;

  assign req_wr    = cmd_is_write(req_cmd[0]);
  assign st_wr     = cmd_is_write(st_cmd[0]);
  assign be_masked = cfg_be_skip && st_pref && !st_wr;

  assign addr_ok = (req_addr == st_addr);
  assign cmd_ok  = cmd_compatible(req_cmd == st_cmd, req_wr, st_wr, cfg_relaxed);
  assign be_ok   = attr_compatible(req_be == st_be, 1'b1, be_masked);
  assign par_ok  = attr_compatible(req_par == st_par, cfg_par_en, 1'b0);
  assign data_ok = attr_compatible(req_wdata == st_wdata, st_wr, 1'b0);
  assign w64_ok  = attr_compatible(req_is64 == st_is64, cfg_64_en, cfg_relaxed);
  assign lock_ok = attr_compatible(req_lock == st_lock, cfg_lock_en, 1'b0);

  assign hit = addr_ok && cmd_ok && be_ok && par_ok && data_ok && w64_ok && lock_ok;

  AST_HIT_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (req_addr == st_addr)); // R4

  AST_WRITE_EXACT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && st_cmd[0]) |-> (req_cmd == st_cmd)); // R7

  AST_STRICT_64: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cfg_relaxed && cfg_64_en) |-> (req_is64 == st_is64)); // R8

endmodule

// File: rtl/dtt_discard.sv
module dtt_discard #(
  parameter int DISCARD_W = 15,
  parameter int DCNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              active,
  input  logic              claim,
  output logic              expire,
  output logic [DCNT_W-1:0] discards
);

  localparam logic [DCNT_W-1:0] CNT_ONE = {{(DCNT_W-1){1'b0}}, 1'b1};

  logic [DISCARD_W-1:0] timer_q;
  logic                 cnt_full;

  // the timer reaches all ones after 2^DISCARD_W - 1 steps in complete
  assign expire   = active && !claim && (&timer_q);
  assign cnt_full = &discards;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      timer_q <= '0;
    else if (arm)    timer_q <= '0;
    else if (active) timer_q <= timer_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   discards <= '0;
    else if (expire && !cnt_full) discards <= discards + CNT_ONE;
  end

  AST_DISCARD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cnt_full) |=> (discards == $past(discards) + CNT_ONE)); // R9

  AST_DISCARD_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_full |=> (&discards)); // R10

  AST_NO_EXPIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !expire); // R9

endmodule

// File: rtl/dly_txn_tracker.sv
module dly_txn_tracker #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BE_W      = 4,
  parameter int CMD_W     = 4,
  parameter int PAR_W     = 1,
  parameter int DISCARD_W = 15,
  parameter int DCNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_relaxed,
  input  logic              cfg_be_skip,
  input  logic              cfg_par_en,
  input  logic              cfg_64_en,
  input  logic              cfg_lock_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [BE_W-1:0]   req_be,
  input  logic [PAR_W-1:0]  req_par,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_is64,
  input  logic              req_lock,
  input  logic              req_pref,
  output logic              rsp_valid,
  output logic              rsp_retry,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [CMD_W-1:0]  fwd_cmd,
  output logic [BE_W-1:0]   fwd_be,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic              fwd_is64,
  output logic              fwd_lock,
  input  logic              cpl_valid,
  input  logic [DATA_W-1:0] cpl_data,
  output logic [1:0]        st_state,
  output logic [DCNT_W-1:0] st_discards
);

  import dtt_pkg::*;

  dt_state_e state_q, state_d;

  logic              cap_en, cpl_take, hit_now, match_hit, expire;
  logic [PAR_W-1:0]  st_par;
  logic              st_pref;
  logic [DATA_W-1:0] st_cdata;

  assign cap_en   = req_valid && (state_q == DT_IDLE);
  assign cpl_take = cpl_valid && (state_q == DT_PEND);
  assign hit_now  = req_valid && (state_q == DT_DONE) && match_hit;

  dtt_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .CMD_W(CMD_W), .PAR_W(PAR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .cfg_par_en(cfg_par_en), .cfg_64_en(cfg_64_en), .cfg_lock_en(cfg_lock_en),
    .in_addr(req_addr), .in_cmd(req_cmd), .in_be(req_be), .in_par(req_par),
    .in_wdata(req_wdata), .in_is64(req_is64), .in_lock(req_lock), .in_pref(req_pref),
    .cpl_load(cpl_take), .cpl_data(cpl_data),
    .st_addr(fwd_addr), .st_cmd(fwd_cmd), .st_be(fwd_be), .st_par(st_par),
    .st_wdata(fwd_wdata), .st_is64(fwd_is64), .st_lock(fwd_lock), .st_pref(st_pref),
    .st_cdata(st_cdata)
  );

  dtt_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .CMD_W(CMD_W), .PAR_W(PAR_W)
  ) u_match (
    .clk(clk), .rst_n(rst_n),
    .cfg_relaxed(cfg_relaxed), .cfg_be_skip(cfg_be_skip), .cfg_par_en(cfg_par_en),
    .cfg_64_en(cfg_64_en), .cfg_lock_en(cfg_lock_en),
    .req_addr(req_addr), .req_cmd(req_cmd), .req_be(req_be), .req_par(req_par),
    .req_wdata(req_wdata), .req_is64(req_is64), .req_lock(req_lock),
    .st_addr(fwd_addr), .st_cmd(fwd_cmd), .st_be(fwd_be), .st_par(st_par),
    .st_wdata(fwd_wdata), .st_is64(fwd_is64), .st_lock(fwd_lock), .st_pref(st_pref),
    .hit(match_hit)
  );

  dtt_discard #(
    .DISCARD_W(DISCARD_W), .DCNT_W(DCNT_W)
  ) u_discard (
    .clk(clk), .rst_n(rst_n), .arm(cpl_take), .active(state_q == DT_DONE),
    .claim(hit_now), .expire(expire), .discards(st_discards)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DT_IDLE: if (cap_en)             state_d = DT_PEND;
      DT_PEND: if (cpl_take)           state_d = DT_DONE;
      DT_DONE: if (hit_now || expire)  state_d = DT_IDLE;
      default:                         state_d = DT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= DT_IDLE;
      rsp_valid <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_data  <= '0;
      fwd_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= req_valid;
      rsp_retry <= req_valid && !hit_now;
      rsp_done  <= hit_now;
      rsp_data  <= hit_now ? st_cdata : '0;
      fwd_valid <= cap_en;
    end
  end

  assign st_state = state_q;

  AST_RESPONSE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == (rsp_retry ^ rsp_done)); // R2

  AST_LAUNCH_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (fwd_valid && st_state == 2'd1 && rsp_retry)); // R2

  AST_PENDING_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DT_PEND && req_valid) |=> rsp_retry); // R3

  AST_HIT_FREES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (st_state == 2'd0)); // R4

  AST_CPL_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DT_IDLE && !req_valid) |=> (st_state == 2'd0)); // R11

endmodule

// File: tb/sim_dly_txn_tracker.sv
module sim_dly_txn_tracker;

  localparam int DW = 6;          // discard window 2^6 cycles for a short run
  localparam int DLEN = 1 << DW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_relaxed = 0, cfg_be_skip = 0, cfg_par_en = 0, cfg_64_en = 0, cfg_lock_en = 0;
  logic        req_valid = 0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic [3:0]  req_be = '0;
  logic [0:0]  req_par = '0;
  logic [31:0] req_wdata = '0;
  logic        req_is64 = 0, req_lock = 0, req_pref = 0;
  logic        rsp_valid, rsp_retry, rsp_done;
  logic [31:0] rsp_data;
  logic        fwd_valid;
  logic [31:0] fwd_addr;
  logic [3:0]  fwd_cmd;
  logic [3:0]  fwd_be;
  logic [31:0] fwd_wdata;
  logic        fwd_is64, fwd_lock;
  logic        cpl_valid = 0;
  logic [31:0] cpl_data = '0;
  logic [1:0]  st_state;
  logic [1:0]  st_discards;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dly_txn_tracker #(.DISCARD_W(DW), .DCNT_W(2)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_relaxed(cfg_relaxed), .cfg_be_skip(cfg_be_skip), .cfg_par_en(cfg_par_en),
    .cfg_64_en(cfg_64_en), .cfg_lock_en(cfg_lock_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd), .req_be(req_be),
    .req_par(req_par), .req_wdata(req_wdata), .req_is64(req_is64), .req_lock(req_lock),
    .req_pref(req_pref),
    .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_done(rsp_done), .rsp_data(rsp_data),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_cmd(fwd_cmd), .fwd_be(fwd_be),
    .fwd_wdata(fwd_wdata), .fwd_is64(fwd_is64), .fwd_lock(fwd_lock),
    .cpl_valid(cpl_valid), .cpl_data(cpl_data),
    .st_state(st_state), .st_discards(st_discards)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // entered at a negedge; one request cycle; returns at the next negedge with the response visible
  task automatic issue(input logic [31:0] a, input logic [3:0] c, input logic [3:0] be,
                       input logic par, input logic [31:0] wd, input logic w64,
                       input logic lk, input logic pf);
    req_addr = a; req_cmd = c; req_be = be; req_par = par; req_wdata = wd;
    req_is64 = w64; req_lock = lk; req_pref = pf; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic complete(input logic [31:0] d);
    cpl_data = d; cpl_valid = 1'b1;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic expect_retry(input string tag);
    chk(rsp_valid && rsp_retry && !rsp_done, tag, {rsp_valid, rsp_retry, rsp_done}, 3'b110);
  endtask

  task automatic expect_hit(input string tag, input logic [31:0] d);
    chk(rsp_valid && rsp_done && !rsp_retry, tag, {rsp_valid, rsp_retry, rsp_done}, 3'b101);
    chk(rsp_data == d, tag, rsp_data, d);
    chk(st_state == 2'd0, tag, st_state, 0);
  endtask

  task automatic t_reset;
    chk(st_state == 2'd0 && st_discards == 2'd0, "R1 state/discards", {st_state, st_discards}, 0);
    chk(!rsp_valid && !rsp_retry && !rsp_done && !fwd_valid, "R1 outputs",
        {rsp_valid, rsp_retry, rsp_done, fwd_valid}, 0);
  endtask

  task automatic t_strict_read;
    issue(32'h1000, 4'h6, 4'hF, 0, 0, 0, 0, 0);
    expect_retry("R2 first retry");
    chk(fwd_valid && fwd_addr == 32'h1000 && fwd_cmd == 4'h6 && fwd_be == 4'hF,
        "R2 launch", {fwd_valid, fwd_addr, fwd_cmd, fwd_be}, {1'b1, 32'h1000, 4'h6, 4'hF});
    chk(st_state == 2'd1, "R2 pending", st_state, 1);
    issue(32'h1000, 4'h6, 4'hF, 0, 0, 0, 0, 0);
    expect_retry("R3 pending retry");
    chk(!fwd_valid, "R3 single launch", fwd_valid, 0);
    complete(32'hCAFE0001);
    chk(st_state == 2'd2, "R3 complete", st_state, 2);
    issue(32'h1000, 4'h6, 4'h3, 0, 0, 0, 0, 0);
    expect_retry("R5 be miss");
    chk(st_state == 2'd2 && fwd_be == 4'hF, "R5 entry kept", {st_state, fwd_be}, {2'd2, 4'hF});
    issue(32'h1000, 4'hC, 4'hF, 0, 0, 0, 0, 0);
    expect_retry("R7 strict no alias");
    issue(32'h1000, 4'h6, 4'hF, 0, 0, 0, 0, 0);
    expect_hit("R4 strict hit", 32'hCAFE0001);
  endtask

  task automatic t_cpl_ignored;
    complete(32'hDEAD);
    chk(st_state == 2'd0, "R11 cpl in idle", st_state, 0);
  endtask

  task automatic t_be_skip;
    cfg_be_skip = 1;
    issue(32'h2000, 4'h6, 4'hF, 0, 0, 0, 0, 0);
    complete(32'h22);
    issue(32'h2000, 4'h6, 4'h1, 0, 0, 0, 0, 0);
    expect_retry("R6 non-prefetchable compares be");
    issue(32'h2000, 4'h6, 4'hF, 0, 0, 0, 0, 0);
    expect_hit("R6 non-pref exact", 32'h22);
    issue(32'h2400, 4'h6, 4'hF, 0, 0, 0, 0, 1);
    complete(32'h24);
    issue(32'h2400, 4'h6, 4'h1, 0, 0, 0, 0, 1);
    expect_hit("R6 pref be masked", 32'h24);
    cfg_be_skip = 0;
  endtask

  task automatic t_relaxed;
    cfg_relaxed = 1;
    issue(32'h3000, 4'h6, 4'hF, 0, 0, 0, 0, 0);
    complete(32'h33);
    issue(32'h3000, 4'hC, 4'hF, 0, 0, 0, 0, 0);
    expect_hit("R7 read alias", 32'h33);
    issue(32'h3100, 4'h7, 4'hF, 0, 32'hAB, 0, 0, 0);
    complete(32'h31);
    issue(32'h3100, 4'h3, 4'hF, 0, 32'hAB, 0, 0, 0);
    expect_retry("R7 write cmd exact");
    issue(32'h3100, 4'h7, 4'hF, 0, 32'hAC, 0, 0, 0);
    expect_retry("R4 write data");
    issue(32'h3100, 4'h7, 4'hF, 0, 32'hAB, 0, 0, 0);
    expect_hit("R7 write exact hit", 32'h31);
    cfg_relaxed = 0;
  endtask

  task automatic t_width_and_parity;
    cfg_64_en = 1; cfg_par_en = 1;
    issue(32'h4000, 4'h6, 4'hF, 1, 0, 1, 0, 0);
    chk(fwd_is64 == 1'b1, "R2 64 flag captured", fwd_is64, 1);
    complete(32'h44);
    issue(32'h4000, 4'h6, 4'hF, 1, 0, 0, 0, 0);
    expect_retry("R8 strict 64 mismatch");
    issue(32'h4000, 4'h6, 4'hF, 0, 0, 1, 0, 0);
    expect_retry("R4 parity mismatch");
    cfg_relaxed = 1;
    issue(32'h4000, 4'h6, 4'hF, 1, 0, 0, 0, 0);
    expect_hit("R8 relaxed 64 to 32", 32'h44);
    cfg_relaxed = 0; cfg_64_en = 0; cfg_par_en = 0;
    cfg_lock_en = 1;
    issue(32'h4100, 4'h6, 4'hF, 0, 0, 0, 1, 0);
    chk(fwd_lock == 1'b1, "R2 lock captured", fwd_lock, 1);
    complete(32'h41);
    issue(32'h4100, 4'h6, 4'hF, 0, 0, 0, 0, 0);
    expect_retry("R4 lock mismatch");
    issue(32'h4100, 4'h6, 4'hF, 0, 0, 0, 1, 0);
    expect_hit("R4 lock hit", 32'h41);
    cfg_lock_en = 0;
  endtask

  task automatic t_discard;
    issue(32'h5000, 4'h6, 4'hF, 0, 0, 0, 0, 0);
    complete(32'h55);
    issue(32'h5004, 4'h6, 4'hF, 0, 0, 0, 0, 0);   // miss during wait, timer unaffected
    expect_retry("R5 miss in complete");
    repeat (DLEN - 2) @(negedge clk);
    chk(st_state == 2'd2, "R9 held until window end", st_state, 2);
    @(negedge clk);
    chk(st_state == 2'd0 && st_discards == 2'd1, "R9 discarded", {st_state, st_discards}, {2'd0, 2'd1});
    issue(32'h5000, 4'h6, 4'hF, 0, 0, 0, 0, 0);
    expect_retry("R9 repeat after discard recaptures");
    chk(fwd_valid, "R9 relaunch", fwd_valid, 1);
    complete(32'h56);
    repeat (DLEN) @(negedge clk);
    chk(st_discards == 2'd2, "R9 second discard", st_discards, 2);
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 2; k++) begin
      issue(32'h6000, 4'h6, 4'hF, 0, 0, 0, 0, 0);
      complete(32'h66);
      repeat (DLEN) @(negedge clk);
    end
    chk(st_discards == 2'd3 && st_state == 2'd0, "R10 saturated", {st_state, st_discards}, {2'd0, 2'd3});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_strict_read();
    t_cpl_ignored();
    t_be_skip();
    t_relaxed();
    t_width_and_parity();
    t_discard();
    t_saturate();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule